// File: doc/BRIEF.md
# Three-Phase Hall Commutation Controller

This block turns three digitised Hall sensor levels into gate enables for a three-phase bipolar bridge. In every valid rotor position one phase is pulled to the supply, one is pulled to ground and one is left floating. Motor power is set by direct PWM. A free-running counter is compared with a duty word, and only the low-side switch of the grounded phase is chopped. The high-side switch stays fully on for as long as its phase is selected.

Around the commutation logic the block applies the drive conditions. An active-low run input stops the bridge. A deceleration request either coasts the motor with every switch open or drives reverse torque, depending on a brake-style select. A rotor-lock fault input removes all low-side drive. A current-limit trip input cuts the low-side pulse for the rest of the PWM period, but only after the trip has lasted a programmable blanking time, so short diode-recovery spikes are ignored. Each phase passes through a guard that keeps it floating for a set number of clocks before it is driven to the opposite rail.

Top module: `bldc_commutator`

## Requirements
- R1: With sensor bits IN1=`hall_in[0]`, IN2=`hall_in[1]`, IN3=`hall_in[2]`, the phase states (phase 1, 2, 3) follow this map, where H means high side on, L means low side on and F means floating. IN1 IN2 IN3 = 101 gives L,H,F. 100 gives L,F,H. 110 gives F,L,H. 010 gives H,L,F. 011 gives H,F,L. 001 gives F,H,L.
- R2: The sensor codes 000 and 111 open all six switches one clock later.
- R3: A high-side enable is steady while its phase is driven high. A low-side enable is asserted only while the PWM counter value is below `duty`. The counter runs from 0 to 2^CNT_W-1, restarts at 0 after reset and steps once per clock. A duty of 0 never turns the low side on.
- R4: While `run_n` is high, all outputs are low from the clock after it is sampled high.
- R5: While `decel_req` is high and `coast_sel` is high, all outputs are low from the next clock.
- R6: While `decel_req` is high and `coast_sel` is low, each phase takes the opposite rail from the R1 map (H and L swap, F stays F).
- R7: When `ilim_trip` has been sampled high on BLANK_CYC consecutive clocks, the low-side pulse is cut from the next clock until the clock after the counter reaches its maximum. A trip shorter than BLANK_CYC clocks has no effect.
- R8: While `lock_fault` is high, all low-side enables are low from the next clock. High-side drive is unaffected.
- R9: A phase that changes from one rail to the other floats for at least DEAD_CYC+1 clocks in between. It never goes directly from H to L or from L to H.
- R10: During reset all outputs are low. Every phase-state change appears one clock after the inputs that cause it are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hall_in | input | 3 | Digitised Hall levels, bit 0 = sensor 1 |
| run_n | input | 1 | Low = run, high = stop |
| decel_req | input | 1 | Deceleration requested by the speed loop |
| coast_sel | input | 1 | Brake style: 1 = coast, 0 = reverse torque |
| ilim_trip | input | 1 | Raw current-limit comparator output |
| lock_fault | input | 1 | Rotor-lock protection active |
| duty | input | CNT_W | PWM on-count per period |
| hs_en | output | 3 | High-side gate enables, bit k = phase k+1 |
| ls_en | output | 3 | Low-side gate enables, bit k = phase k+1 |

## Verification
A phase state register holding a wrong value shows up at the gate enables in the same cycle, as a wrong rail or a missing float gap. It is caught against the reference on the next compare. A wrong PWM counter or chop flag is less direct: it shows only while a phase is low-side driven, within one PWM period. A wrong blanking counter shows only at the end of a sustained trip, so the trip tests hold the trip both just under and well past the blanking length.

// File: rtl/bldc_pkg.sv
package bldc_pkg;
   localparam int NPH = 3;
   typedef enum logic [1:0] {
      PH_FLOAT = 2'd0,
      PH_HIGH  = 2'd1,
      PH_LOW   = 2'd2
   } phase_t;
endpackage

// File: rtl/phase_select.sv
module phase_select
   import bldc_pkg::*;
(
   input  logic   own_bit,
   input  logic   next_bit,
   input  logic   code_ok,
   input  logic   drive_en,
   input  logic   reverse,
   input  logic   lock_fault,
   output phase_t want
);
   phase_t base;

   always_comb begin
      base = PH_FLOAT;
      if (own_bit && !next_bit)      base = PH_LOW;
      else if (!own_bit && next_bit) base = PH_HIGH;
   end

   always_comb begin
      want = base;
      if (reverse) begin
         if (base == PH_LOW)       want = PH_HIGH;
         else if (base == PH_HIGH) want = PH_LOW;
      end
      if (!code_ok || !drive_en)               want = PH_FLOAT;
      if (lock_fault && (want == PH_LOW))      want = PH_FLOAT;
   end
endmodule

// File: rtl/dead_guard.sv
module dead_guard
   import bldc_pkg::*;
#(
   parameter int DEAD_CYC = 16
) (
   input  logic   clk,
   input  logic   rst_n,
   input  phase_t want,
   output phase_t act
);
   localparam int IW = $clog2(DEAD_CYC + 1);
   localparam logic [IW-1:0] DEAD_V = IW'(DEAD_CYC);

   initial assert (DEAD_CYC >= 1) else $error("dead_guard: DEAD_CYC must be at least 1");

   phase_t        act_q, act_d;
   logic [IW-1:0] idle_q, idle_d;

   always_comb begin
      act_d  = act_q;
      idle_d = idle_q;
      if (want == act_q) begin
         if (act_q == PH_FLOAT) begin
            if (idle_q < DEAD_V) idle_d = idle_q + 1'b1;
         end else begin
            idle_d = '0;
         end
      end else if (act_q != PH_FLOAT) begin
         act_d  = PH_FLOAT;
         idle_d = '0;
      end else if (idle_q >= DEAD_V) begin
         act_d  = want;
         idle_d = '0;
      end else begin
         idle_d = idle_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= PH_FLOAT;
         idle_q <= DEAD_V;
      end else begin
         act_q  <= act_d;
         idle_q <= idle_d;
      end
   end

   assign act = act_q;

   AST_NO_HIGH_TO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q == PH_HIGH) |=> (act_q != PH_LOW)); // R9
   AST_NO_LOW_TO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q == PH_LOW) |=> (act_q != PH_HIGH)); // R9
endmodule

// File: rtl/pwm_chopper.sv
module pwm_chopper #(
   parameter int CNT_W     = 8,
   parameter int BLANK_CYC = 250
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] duty,
   input  logic             ilim_trip,
   output logic             pwm_on
);
   localparam int BW = $clog2(BLANK_CYC + 1);
   localparam logic [BW-1:0]    BLANK_V  = BW'(BLANK_CYC);
   localparam logic [BW-1:0]    BLANK_M1 = BW'(BLANK_CYC - 1);
   localparam logic [CNT_W-1:0] CNT_MAX  = '1;

   initial assert (CNT_W >= 2 && CNT_W <= 16) else $error("pwm_chopper: CNT_W out of range");
   initial assert (BLANK_CYC >= 1) else $error("pwm_chopper: BLANK_CYC must be at least 1");

   logic [CNT_W-1:0] cnt_q;
   logic [BW-1:0]    trip_q;
   logic             chop_q;
   logic             trip_long;

   assign trip_long = ilim_trip && (trip_q >= BLANK_M1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         trip_q <= '0;
         chop_q <= 1'b0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
         if (!ilim_trip)              trip_q <= '0;
         else if (trip_q < BLANK_V)   trip_q <= trip_q + 1'b1;
         if (cnt_q == CNT_MAX)        chop_q <= 1'b0;
         else if (trip_long)          chop_q <= 1'b1;
      end
   end

   assign pwm_on = (cnt_q < duty) && !chop_q;

   AST_CHOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (chop_q && (cnt_q != CNT_MAX)) |=> chop_q); // R7
   AST_CHOP_NEEDS_TRIP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chop_q) |-> $past(ilim_trip)); // R7
   AST_CHOP_ENDS_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_MAX) |=> !chop_q); // R7
endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator
   import bldc_pkg::*;
#(
   parameter int CNT_W     = 8,
   parameter int BLANK_CYC = 250,
   parameter int DEAD_CYC  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       hall_in,
   input  logic             run_n,
   input  logic             decel_req,
   input  logic             coast_sel,
   input  logic             ilim_trip,
   input  logic             lock_fault,
   input  logic [CNT_W-1:0] duty,
   output logic [2:0]       hs_en,
   output logic [2:0]       ls_en
);
   logic code_ok, drive_en, reverse, pwm_on;

   assign code_ok  = (hall_in != 3'b000) && (hall_in != 3'b111);
   assign drive_en = !run_n && !(decel_req && coast_sel);
   assign reverse  = decel_req && !coast_sel;

   pwm_chopper #(.CNT_W(CNT_W), .BLANK_CYC(BLANK_CYC)) u_pwm (
      .clk(clk), .rst_n(rst_n), .duty(duty), .ilim_trip(ilim_trip), .pwm_on(pwm_on)
   );

   for (genvar k = 0; k < NPH; k++) begin : g_phase
      phase_t want, act;

      phase_select u_sel (
         .own_bit(hall_in[k]), .next_bit(hall_in[(k + 1) % NPH]),
         .code_ok(code_ok), .drive_en(drive_en), .reverse(reverse),
         .lock_fault(lock_fault), .want(want)
      );

      dead_guard #(.DEAD_CYC(DEAD_CYC)) u_guard (
         .clk(clk), .rst_n(rst_n), .want(want), .act(act)
      );

      assign hs_en[k] = (act == PH_HIGH);
      assign ls_en[k] = (act == PH_LOW) && pwm_on;
   end

   AST_STOP_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      run_n |=> (hs_en == 3'b000 && ls_en == 3'b000)); // R4
   AST_COAST_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (decel_req && coast_sel) |=> (hs_en == 3'b000 && ls_en == 3'b000)); // R5
   AST_BAD_CODE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (hall_in == 3'b000 || hall_in == 3'b111) |=> (hs_en == 3'b000 && ls_en == 3'b000)); // R2
   AST_LOCK_NO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      lock_fault |=> (ls_en == 3'b000)); // R8
   AST_ONE_LOW_SIDE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ls_en) && $onehot0(hs_en)); // R1
endmodule

// File: tb/bldc_commutator_test.sv
module bldc_commutator_test;
   localparam int CW = 5;
   localparam int BL = 6;
   localparam int DT = 3;
   localparam int CMAX = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    hall_in = 3'b101;
   logic          run_n = 1'b1, decel_req = 1'b0, coast_sel = 1'b1;
   logic          ilim_trip = 1'b0, lock_fault = 1'b0;
   logic [CW-1:0] duty = '0;
   logic [2:0]    hs_en, ls_en;

   int    n_run = 0, n_fail = 0;
   string tag = "R10";
   int    m_cnt, m_trip, m_chop;
   int    m_act[3], m_idle[3];

   always #4 clk = ~clk;

   bldc_commutator #(.CNT_W(CW), .BLANK_CYC(BL), .DEAD_CYC(DT)) uut (
      .clk(clk), .rst_n(rst_n), .hall_in(hall_in), .run_n(run_n),
      .decel_req(decel_req), .coast_sel(coast_sel), .ilim_trip(ilim_trip),
      .lock_fault(lock_fault), .duty(duty), .hs_en(hs_en), .ls_en(ls_en)
   );

   // 0 = float, 1 = high, 2 = low; table indexed by IN1 IN2 IN3
   function automatic int tbl(logic [2:0] h, int k);
      int r[3];
      case ({h[0], h[1], h[2]})
         3'b101: r = '{2, 1, 0};
         3'b100: r = '{2, 0, 1};
         3'b110: r = '{0, 2, 1};
         3'b010: r = '{1, 2, 0};
         3'b011: r = '{1, 0, 2};
         3'b001: r = '{0, 1, 2};
         default: r = '{0, 0, 0};
      endcase
      return r[k];
   endfunction

   function automatic int want_of(int k);
      int w = tbl(hall_in, k);
      if (decel_req && !coast_sel) w = (w == 1) ? 2 : (w == 2) ? 1 : 0;
      if (run_n || (decel_req && coast_sel)) w = 0;
      if (lock_fault && w == 2) w = 0;
      return w;
   endfunction

   task automatic model_reset();
      m_cnt = 0; m_trip = 0; m_chop = 0;
      for (int k = 0; k < 3; k++) begin m_act[k] = 0; m_idle[k] = DT; end
   endtask

   task automatic model_step();
      int na[3], ni[3];
      int nchop;
      for (int k = 0; k < 3; k++) begin
         int w = want_of(k);
         na[k] = m_act[k];
         if (w == m_act[k]) ni[k] = (m_act[k] == 0) ? ((m_idle[k] < DT) ? m_idle[k] + 1 : DT) : 0;
         else if (m_act[k] != 0) begin na[k] = 0; ni[k] = 0; end
         else if (m_idle[k] >= DT) begin na[k] = w; ni[k] = 0; end
         else ni[k] = m_idle[k] + 1;
      end
      nchop = (m_cnt == CMAX) ? 0 : ((m_chop != 0 || (ilim_trip && m_trip >= BL - 1)) ? 1 : 0);
      m_trip = ilim_trip ? ((m_trip < BL) ? m_trip + 1 : BL) : 0;
      m_chop = nchop;
      m_cnt = (m_cnt + 1) % (CMAX + 1);
      for (int k = 0; k < 3; k++) begin m_act[k] = na[k]; m_idle[k] = ni[k]; end
   endtask

   task automatic compare();
      logic [2:0] eh, el;
      for (int k = 0; k < 3; k++) begin
         eh[k] = (m_act[k] == 1);
         el[k] = (m_act[k] == 2) && (m_cnt < int'(duty)) && (m_chop == 0);
      end
      n_run++;
      if (hs_en !== eh || ls_en !== el) begin
         n_fail++;
         $display("FAIL %s: hs=%b ls=%b expected hs=%b ls=%b", tag, hs_en, ls_en, eh, el);
      end
   endtask

   task automatic tick(int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         if (!rst_n) model_reset(); else model_step();
         #2;
         compare();
      end
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [2:0] seq[6];
      seq = '{3'b101, 3'b001, 3'b011, 3'b010, 3'b110, 3'b100};
      model_reset();
      tag = "R10 reset"; tick(3);
      rst_n = 1'b1;
      tag = "R4 stopped"; duty = 5'd12; tick(10);
      run_n = 1'b0;
      tag = "R1 forward rotation";
      for (int r = 0; r < 2; r++)
         for (int s = 0; s < 6; s++) begin hall_in = seq[s]; tick(20); end
      tag = "R3 zero duty"; duty = 5'd0; tick(40);
      tag = "R3 near full duty"; duty = 5'd31; tick(40);
      tag = "R3 mid duty"; duty = 5'd9;
      for (int s = 5; s >= 0; s--) begin hall_in = seq[s]; tick(20); end
      tag = "R2 code 000"; hall_in = 3'b000; tick(10);
      tag = "R2 code 111"; hall_in = 3'b111; tick(10);
      hall_in = 3'b101; tag = "R1 recover"; tick(12);
      tag = "R6 R9 reverse torque"; decel_req = 1'b1; coast_sel = 1'b0; duty = 5'd20;
      for (int s = 0; s < 6; s++) begin hall_in = seq[s]; tick(16); end
      tag = "R9 back to forward"; decel_req = 1'b0; tick(12);
      tag = "R5 coast"; decel_req = 1'b1; coast_sel = 1'b1; tick(15);
      decel_req = 1'b0; tick(10);
      tag = "R8 lock fault"; lock_fault = 1'b1;
      for (int s = 0; s < 6; s++) begin hall_in = seq[s]; tick(10); end
      lock_fault = 1'b0; tag = "R8 release"; tick(10);
      hall_in = 3'b101; duty = 5'd31; tick(40);
      tag = "R7 short trip ignored";
      for (int p = 0; p < 4; p++) begin ilim_trip = 1'b1; tick(BL - 1); ilim_trip = 1'b0; tick(7); end
      tag = "R7 sustained trip"; ilim_trip = 1'b1; tick(70);
      ilim_trip = 1'b0; tag = "R7 trip cleared"; tick(40);
      tag = "R4 stop while driving"; run_n = 1'b1; tick(15);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule